// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block models a single programmable I/O cell of a complex programmable logic device, with its configuration bits as ports. A two-bit direction field makes the cell an input only, an output only, or a bidirectional pin with a 3-state driver. A second two-bit field picks the signal that enables the driver in bidirectional mode. The choices are a product-term enable from the logic array, either of two chip-wide output-enable inputs, or a constant enable.

A drive-type bit chooses between a push-pull (totem-pole) driver and an open-drain driver. The push-pull driver forces both levels. The open-drain driver only pulls low, and releases the pad to high impedance for a logic 1. With every configuration bit at 0, the erased condition, the cell is an input with the push-pull drive type. The input path is purely combinational and always returns the pad level to the routing fabric, so a value the cell drives can be read back.

Top module: `pio_cell`

## Requirements
- R1: With the direction field `cfg_dir` at 2'b00 or 2'b11, the cell never drives the pad, whatever the enable sources and data are. The pad then shows the pull-up level (1), or the level an external driver forces.
- R2: With `cfg_dir` at 2'b01 (output only), the driver is enabled regardless of `pt_oe`, `goe` and `cfg_oe_sel`.
- R3: With `cfg_dir` at 2'b10 (bidirectional), the driver is enabled only when the source picked by `cfg_oe_sel` is 1. The codes are 2'b00 for `pt_oe`, 2'b01 for `goe[0]`, 2'b10 for `goe[1]`, and 2'b11 for always enabled.
- R4: With `cfg_odrain` at 0 (push-pull), an enabled driver puts `core_out` on the pad for both 0 and 1.
- R5: With `cfg_odrain` at 1 (open-drain), an enabled driver pulls the pad to 0 when `core_out` is 0. It leaves the pad at high impedance when `core_out` is 1, and whenever the driver is disabled.
- R6: In the erased state (all configuration inputs 0), the pad is undriven and reads the pull-up level. Changing only `cfg_dir` to output mode then gives push-pull drive of both levels, because the erased value of `cfg_odrain` is push-pull.
- R7: `core_in` always equals the level on the pad in every mode, including the cell's own driven value in output and bidirectional modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_dir | input | 2 | Direction: 00/11 input, 01 output, 10 bidirectional |
| cfg_odrain | input | 1 | Drive type: 0 push-pull, 1 open-drain |
| cfg_oe_sel | input | 2 | Enable source for bidirectional mode |
| core_out | input | 1 | Data from the logic array to the pad |
| pt_oe | input | 1 | Product-term output enable |
| goe | input | 2 | Chip-wide output-enable inputs |
| pad | inout | 1 | Device pin |
| core_in | output | 1 | Pad level returned to the routing fabric |

## Verification
Every combination of direction, drive type, enable source, data and the three enable inputs is applied. This separates the correct enable selection from any neighbouring source, and the mode-dependent gating from the data path. Each combination is applied twice: once with only a weak pull-up on the pad, and once with an external driver forcing 0. A driven 0 shows up as a low pad under the pull-up. A released pad shows up as a pad that follows the external 0, which tells high impedance apart from an actively driven 1. The returned input is compared against the expected pad level in each case.

// File: rtl/pio_cell.sv
module pio_cell (
  input  logic [1:0] cfg_dir,
  input  logic       cfg_odrain,
  input  logic [1:0] cfg_oe_sel,
  input  logic       core_out,
  input  logic       pt_oe,
  input  logic [1:0] goe,
  inout  wire        pad,
  output logic       core_in
);
  localparam logic [1:0] DIR_OUT = 2'b01;
  localparam logic [1:0] DIR_BI  = 2'b10;

  logic out_mode, bidir, sel_en, gate_on, drv_en, drv_val;

  always_comb begin
    unique case (cfg_oe_sel)
      2'b00:   sel_en = pt_oe;
      2'b01:   sel_en = goe[0];
      2'b10:   sel_en = goe[1];
      default: sel_en = 1'b1;
    endcase
  end

  assign out_mode = (cfg_dir == DIR_OUT);
  assign bidir    = (cfg_dir == DIR_BI);
  assign gate_on  = out_mode | (bidir & sel_en);
  assign drv_en   = gate_on & ~(cfg_odrain & core_out);
  assign drv_val  = ~cfg_odrain & core_out;

  assign pad     = drv_en ? drv_val : 1'bz;
  assign core_in = pad;

  always_comb begin
    // R1
    in_only_quiet_chk: assert (out_mode || bidir || !drv_en);
    // R5
    od_low_only_chk: assert (!(cfg_odrain && drv_en) || !drv_val);
    // R2
    out_always_chk: assert (!(out_mode && !cfg_odrain) || (drv_en && drv_val == core_out));
    // R3
    bi_const_en_chk: assert (!(bidir && cfg_oe_sel == 2'b11 && !cfg_odrain) || drv_en);
  end
endmodule

// File: tb/pio_cell_bench.sv
module pio_cell_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cfg_dir = '0, cfg_oe_sel = '0, goe = '0;
  logic cfg_odrain = 1'b0, core_out = 1'b0, pt_oe = 1'b0;
  logic ext_en = 1'b0, ext_val = 1'b0;
  logic core_in;
  wire  pad;

  pullup (pad);
  assign pad = ext_en ? ext_val : 1'bz;

  pio_cell u_pio_cell (
    .cfg_dir(cfg_dir), .cfg_odrain(cfg_odrain), .cfg_oe_sel(cfg_oe_sel),
    .core_out(core_out), .pt_oe(pt_oe), .goe(goe), .pad(pad), .core_in(core_in)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dir=%0d od=%0d sel=%0d out=%0d pt=%0d goe=%0d ext=%0d act=%b exp=%b",
               tag, cfg_dir, cfg_odrain, cfg_oe_sel, core_out, pt_oe, goe, ext_en, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // R6: erased configuration leaves pad on pull-up
    chk("R6 erased pad", pad, 1'b1);
    chk("R6 erased core_in", core_in, 1'b1);
    @(negedge clk); cfg_dir = 2'b01; core_out = 1'b0; settle();
    chk("R6 erased drive type low", pad, 1'b0);
    @(negedge clk); ext_en = 1'b1; ext_val = 1'b0; core_out = 1'b1; ext_en = 1'b0; settle();
    chk("R6 erased drive type high", pad, 1'b1);
    @(negedge clk); ext_en = 1'b1; core_out = 1'b0; settle();
    chk("R4 push-pull low vs external 0", pad, 1'b0);
    @(negedge clk); ext_en = 1'b0; settle();

    for (int d = 0; d < 4; d++)
      for (int od = 0; od < 2; od++)
        for (int s = 0; s < 4; s++)
          for (int co = 0; co < 2; co++)
            for (int en = 0; en < 8; en++)
              for (int ex = 0; ex < 2; ex++) begin
                logic sel, gate, drives, val, exp_pad;
                string tag;
                sel = (s == 0) ? en[0] : (s == 1) ? en[1] : (s == 2) ? en[2] : 1'b1;
                gate = (d == 1) || (d == 2 && sel);
                drives = gate && !(od == 1 && co == 1);
                val = (od == 0) && (co == 1);
                if (ex == 1 && drives && val) continue;
                exp_pad = drives ? val : (ex == 1 ? 1'b0 : 1'b1);
                if (d == 0 || d == 3) tag = "R1";
                else if (od == 1) tag = "R5";
                else if (d == 1) tag = "R2";
                else tag = "R3";
                @(negedge clk);
                cfg_dir = 2'(d); cfg_odrain = od[0]; cfg_oe_sel = 2'(s);
                core_out = co[0]; pt_oe = en[0]; goe = {en[2], en[1]};
                ext_en = ex[0]; ext_val = 1'b0;
                settle();
                chk(tag, pad, exp_pad);
                if (drives && od == 0) chk("R4", pad, co[0]);
                chk("R7", core_in, exp_pad);
              end
    done = 1'b1;
    finish_run();
  end
endmodule